// File: doc/BRIEF.md
# Dual-Clock 8-bit Timer with Staged Register Writes

This block is an 8-bit counter with a compare register and a small bus-side register file. It can count on either the bus clock or a separate slow oscillator clock. A glitch-free clock selector picks the source. The counter, compare and run-enable registers sit in that selected timer clock domain.

Every bus write to one of those three registers lands first in a bus-side holding register. A toggle handshake then carries it across, and a per-register busy bit stays high until the timer side has taken the value. Match and overflow events travel back as toggles. In the bus domain they set sticky flags, which are gated by mask bits onto two interrupt pins.

Software writes a register and then polls its busy bit before writing the same register again. A write made while the bit is still high is dropped and recorded in a sticky error bit. Reading the count returns the counter value, sampled through two bus flops. Reading compare or control returns the holding register.

Top module: `staged_timer`

Register map (3-bit `addr`):

| Addr | Content |
|------|---------|
| 0 | count |
| 1 | compare |
| 2 | control: bit 0 = run |
| 3 | status: bit 3 = clock select (writable); bits 2, 1, 0 = busy for count, compare, control (read-only) |
| 4 | mask: bit 1 = match enable, bit 0 = overflow enable |
| 5 | flags: bit 1 = match, bit 0 = overflow; write one to clear |
| 6 | error: bit 0 = sticky dropped-write error |

## Requirements
- R1: After reset, every readable register at addresses 0 to 6 reads zero, and `irq_match`, `irq_ovf` and `wave_out` are low.
- R2: Status bit 3 selects the counting clock: 0 selects the bus clock, 1 selects `osc_clk`. The bit reads back as written, and the timer counts and raises events in either mode.
- R3: A write to count, compare or control sets status bit 2, 1 or 0 respectively. The bit is visible in the cycle after the write and clears by itself once the timer domain has taken the value.
- R4: Address 0 returns the counter value. Addresses 1 and 2 return the holding register, which shows a written value in the cycle after the write, before the transfer completes.
- R5: A write to count, compare or control while that register's busy bit is set is discarded: the holding register and the timer keep the earlier value. The write also sets error bit 0 at address 6, which stays set until reset.
- R6: With control bit 0 set, the counter advances by one on each timer clock edge. With it clear, the counter holds its value.
- R7: On a counting edge where count equals compare, flag bit 1 (address 5) sets. On a counting edge at count 255, the counter wraps to 0 and flag bit 0 sets.
- R8: A count write suppresses the compare match on the first counting edge after it lands in the timer domain.
- R9: Writing a one to a flag bit clears it, and writing a zero leaves it unchanged. An event arriving in the same cycle as the clear wins.
- R10: `irq_match` is high when flag bit 1 and mask bit 1 are both set. `irq_ovf` is high when flag bit 0 and mask bit 0 are both set.
- R11: `wave_out` toggles on every compare match that is not suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock; also a timer clock choice |
| osc_clk | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_match | output | 1 | Masked compare-match interrupt |
| irq_ovf | output | 1 | Masked overflow interrupt |
| wave_out | output | 1 | Level that toggles on each match |

## Verification
The interesting collision is a count write landing in the timer domain on the edge just before the counter would meet the compare value. Loading the count and evaluating the match then fall on consecutive timer edges.

The bench provokes this by starting the counter and then writing the count equal to the compare value. It judges the result from the order of interrupt events in its scoreboard: overflow must come first and the match only a full wrap later. It also checks that `wave_out` flips exactly once.

A second pairing is a busy register receiving a new write. The bench judges that by reading back the holding value and by watching that the counter stays stopped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_COUNT = 3'd0,
    A_CMP   = 3'd1,
    A_CTRL  = 3'd2,
    A_STAT  = 3'd3,
    A_MASK  = 3'd4,
    A_FLAG  = 3'd5,
    A_ERR   = 3'd6
  } reg_addr_e;

  localparam int N_EVT  = 2;  // bit 1 match, bit 0 overflow
  localparam int N_CHAN = 3;  // count, compare, control
endpackage

// File: rtl/clk_pick.sv
module clk_pick (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  output logic clk_o
);
  logic a_s1, a_en, b_s1, b_en;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) a_s1 <= 1'b0;
    else        a_s1 <= !sel && !b_en;

  always_ff @(negedge clk_a or negedge rst_n)
    if (!rst_n) a_en <= 1'b0;
    else        a_en <= a_s1;

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) b_s1 <= 1'b0;
    else        b_s1 <= sel && !a_en;

  always_ff @(negedge clk_b or negedge rst_n)
    if (!rst_n) b_en <= 1'b0;
    else        b_en <= b_s1;

  assign clk_o = (clk_a && a_en) || (clk_b && b_en);

  always_comb begin
    // R2
    src_excl_chk: assert (!(a_en && b_en));
  end
endmodule

// File: rtl/wr_stage.sv
module wr_stage #(
  parameter int W = 8
) (
  input  logic         bclk,
  input  logic         brst_n,
  input  logic         cclk,
  input  logic         crst_n,
  input  logic         wr,
  input  logic [W-1:0] wdat,
  output logic [W-1:0] hold,
  output logic         busy,
  output logic         drop,
  output logic         load
);
  logic req_q, a1, a2;
  logic r1, r2, r3;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      hold  <= '0;
      req_q <= 1'b0;
      a1    <= 1'b0;
      a2    <= 1'b0;
    end else begin
      a1 <= r3;
      a2 <= a1;
      if (wr && !busy) begin
        hold  <= wdat;
        req_q <= !req_q;
      end
    end
  end

  assign busy = req_q ^ a2;
  assign drop = wr && busy;

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      r1 <= 1'b0;
      r2 <= 1'b0;
      r3 <= 1'b0;
    end else begin
      r1 <= req_q;
      r2 <= r1;
      r3 <= r2;
    end
  end

  assign load = r2 ^ r3;

  // R5
  hold_lock_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (wr && busy) |=> $stable(hold));

  // R3
  busy_set_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (wr && !busy) |=> busy);
endmodule

// File: rtl/evt_sync.sv
module evt_sync (
  input  logic bclk,
  input  logic brst_n,
  input  logic tgl,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tgl;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 ^ s3;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_cnt,
  input  logic [DW-1:0] cnt_v,
  input  logic          ld_cmp,
  input  logic [DW-1:0] cmp_v,
  input  logic          ld_run,
  input  logic          run_v,
  output logic [DW-1:0] cnt,
  output logic          match_tgl,
  output logic          ovf_tgl,
  output logic          wave
);
  localparam logic [DW-1:0] TOP = '1;

  logic [DW-1:0] cmp_q;
  logic          run_q;
  logic          blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cmp_q     <= '0;
      run_q     <= 1'b0;
      blk_q     <= 1'b0;
      match_tgl <= 1'b0;
      ovf_tgl   <= 1'b0;
      wave      <= 1'b0;
    end else begin
      if (ld_cmp) cmp_q <= cmp_v;
      if (ld_run) run_q <= run_v;
      if (ld_cnt) begin
        cnt   <= cnt_v;
        blk_q <= 1'b1;
      end else if (run_q) begin
        if (cnt == cmp_q && !blk_q) begin
          match_tgl <= !match_tgl;
          wave      <= !wave;
        end
        if (cnt == TOP) ovf_tgl <= !ovf_tgl;
        cnt   <= cnt + 1'b1;
        blk_q <= 1'b0;
      end
    end
  end

  // R8
  blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && blk_q && !ld_cnt) |=> $stable(match_tgl));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ld_cnt && cnt == TOP) |=> (cnt == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ld_cnt) |=> $stable(cnt));
endmodule

// File: rtl/staged_timer.sv
module staged_timer
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          bus_clk,
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_match,
  output logic          irq_ovf,
  output logic          wave_out
);
  logic                core_clk;
  logic                cr1, crst_n;
  logic                sel_q, err_q;
  logic [N_EVT-1:0]    mask_q, flag_q, tgl_v, pulse_v;
  logic [N_CHAN-1:0]   busy_v, drop_v;
  logic [DW-1:0]       hold_cnt, hold_cmp, core_cnt, cv1, cv2;
  logic                hold_ctl;
  logic                ld_cnt, ld_cmp, ld_ctl;
  logic                match_tgl, ovf_tgl;
  logic                wr_cnt, wr_cmp, wr_ctl, wr_flag;

  assign wr_cnt  = wr_en && addr == A_COUNT;
  assign wr_cmp  = wr_en && addr == A_CMP;
  assign wr_ctl  = wr_en && addr == A_CTRL;
  assign wr_flag = wr_en && addr == A_FLAG;

  clk_pick u_pick (
    .clk_a(bus_clk), .clk_b(osc_clk), .rst_n(rst_n), .sel(sel_q), .clk_o(core_clk)
  );

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      cr1    <= 1'b0;
      crst_n <= 1'b0;
    end else begin
      cr1    <= 1'b1;
      crst_n <= cr1;
    end
  end

  wr_stage #(.W(DW)) u_cnt_stage (
    .bclk(bus_clk), .brst_n(rst_n), .cclk(core_clk), .crst_n(crst_n),
    .wr(wr_cnt), .wdat(wdata), .hold(hold_cnt),
    .busy(busy_v[2]), .drop(drop_v[2]), .load(ld_cnt)
  );

  wr_stage #(.W(DW)) u_cmp_stage (
    .bclk(bus_clk), .brst_n(rst_n), .cclk(core_clk), .crst_n(crst_n),
    .wr(wr_cmp), .wdat(wdata), .hold(hold_cmp),
    .busy(busy_v[1]), .drop(drop_v[1]), .load(ld_cmp)
  );

  wr_stage #(.W(1)) u_ctl_stage (
    .bclk(bus_clk), .brst_n(rst_n), .cclk(core_clk), .crst_n(crst_n),
    .wr(wr_ctl), .wdat(wdata[0]), .hold(hold_ctl),
    .busy(busy_v[0]), .drop(drop_v[0]), .load(ld_ctl)
  );

  tmr_core #(.DW(DW)) u_core (
    .clk(core_clk), .rst_n(crst_n),
    .ld_cnt(ld_cnt), .cnt_v(hold_cnt),
    .ld_cmp(ld_cmp), .cmp_v(hold_cmp),
    .ld_run(ld_ctl), .run_v(hold_ctl),
    .cnt(core_cnt), .match_tgl(match_tgl), .ovf_tgl(ovf_tgl), .wave(wave_out)
  );

  assign tgl_v = {match_tgl, ovf_tgl};

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    evt_sync u_sync (
      .bclk(bus_clk), .brst_n(rst_n), .tgl(tgl_v[i]), .pulse(pulse_v[i])
    );

    always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n)                       flag_q[i] <= 1'b0;
      else if (pulse_v[i])              flag_q[i] <= 1'b1;
      else if (wr_flag && wdata[i])     flag_q[i] <= 1'b0;
    end

    // R7
    flag_set_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      pulse_v[i] |=> flag_q[i]);

    // R9
    flag_clr_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_flag && wdata[i] && !pulse_v[i]) |=> !flag_q[i]);
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      mask_q <= '0;
      err_q  <= 1'b0;
      cv1    <= '0;
      cv2    <= '0;
    end else begin
      cv1 <= core_cnt;
      cv2 <= cv1;
      if (wr_en && addr == A_STAT) sel_q  <= wdata[3];
      if (wr_en && addr == A_MASK) mask_q <= wdata[N_EVT-1:0];
      if (|drop_v)                 err_q  <= 1'b1;
    end
  end

  assign irq_match = flag_q[1] && mask_q[1];
  assign irq_ovf   = flag_q[0] && mask_q[0];

  always_comb begin
    case (addr)
      A_COUNT: rdata = cv2;
      A_CMP:   rdata = hold_cmp;
      A_CTRL:  rdata = {{(DW-1){1'b0}}, hold_ctl};
      A_STAT:  rdata = DW'({sel_q, busy_v});
      A_MASK:  rdata = DW'(mask_q);
      A_FLAG:  rdata = DW'(flag_q);
      A_ERR:   rdata = DW'(err_q);
      default: rdata = '0;
    endcase
  end

  // R5
  err_stick_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (|drop_v) |=> err_q);

  // R10
  irq_mask_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !mask_q[1] |-> !irq_match);
endmodule

// File: tb/tb_staged_timer.sv
module tb_staged_timer;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_PERIOD = 74;
  localparam int EV_MATCH = 1;
  localparam int EV_OVF   = 0;

  logic       bus_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst_n   = 1'b1;
  logic       wr_en   = 1'b0;
  logic [2:0] addr    = '0;
  logic [7:0] wdata   = '0;
  logic [7:0] rdata;
  logic       irq_match, irq_ovf, wave_out;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  staged_timer dut (
    .bus_clk(bus_clk), .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_match(irq_match), .irq_ovf(irq_ovf), .wave_out(wave_out)
  );

  always #(CLK_PERIOD/2) bus_clk = !bus_clk;
  always #(OSC_PERIOD/2) osc_clk = !osc_clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge bus_clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] v;
    for (int k = 0; k < 2000; k++) begin
      rd(3'd3, v);
      if (v[2:0] == 3'b000) return;
    end
    chk({tag, " busy timeout"}, v & 8'h07, 8'h00);
  endtask

  task automatic wait_events(input string tag);
    for (int k = 0; k < 20000; k++) begin
      if (exp_q.size() == 0) return;
      @(negedge bus_clk);
    end
    chk({tag, " missing event"}, 8'(exp_q.size()), 8'h00);
  endtask

  // scoreboard monitor: each rising interrupt must match the next expected event
  task automatic got(input int ev);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R7/R10 unexpected event actual %0d expected none", ev);
    end else begin
      int e;
      e = exp_q.pop_front();
      if (e != ev) begin
        errors++;
        $display("FAIL R7/R8 event order actual %0d expected %0d", ev, e);
      end
    end
  endtask

  initial begin
    logic pm = 1'b0, po = 1'b0;
    forever begin
      @(negedge bus_clk);
      if (rst_n) begin
        if (irq_match && !pm) got(EV_MATCH);
        if (irq_ovf && !po)   got(EV_OVF);
      end
      pm = irq_match;
      po = irq_ovf;
    end
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, c1;
    #3 rst_n = 1'b0;
    repeat (5) @(posedge bus_clk);
    rst_n = 1'b1;
    repeat (10) @(posedge bus_clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 addr %0d", a), v, 8'h00);
    end
    chk("R1 outputs", {5'b0, irq_match, irq_ovf, wave_out}, 8'h00);

    wr(3'd4, 8'h03);
    rd(3'd4, v); chk("R10 mask readback", v, 8'h03);

    // R3 / R4 staged compare
    wr(3'd1, 8'd200);
    rd(3'd3, v); chk("R3 compare busy", v, 8'h02);
    rd(3'd1, v); chk("R4 compare holding", v, 8'd200);
    wait_idle("R3");
    rd(3'd3, v); chk("R3 busy cleared", v, 8'h00);

    // R5 dropped write on busy control register
    wr(3'd2, 8'h00);
    wr(3'd2, 8'h01);
    rd(3'd6, v); chk("R5 error sticky", v, 8'h01);
    rd(3'd2, v); chk("R5 holding kept", v, 8'h00);
    wait_idle("R5");
    wr(3'd0, 8'd0);
    wait_idle("R5");
    repeat (30) @(negedge bus_clk);
    rd(3'd0, v); chk("R5 counter not started", v, 8'd0);

    // R4 live count
    wr(3'd0, 8'd7);
    wait_idle("R4");
    repeat (4) @(negedge bus_clk);
    rd(3'd0, v); chk("R4 count read", v, 8'd7);

    // R7 / R6 match then overflow on bus clock
    wr(3'd0, 8'd0);
    wait_idle("R7");
    exp_q.push_back(EV_MATCH);
    exp_q.push_back(EV_OVF);
    wr(3'd2, 8'h01);
    wait_events("R7");
    wr(3'd2, 8'h00);
    wait_idle("R6");
    rd(3'd5, v); chk("R7 both flags", v, 8'h03);
    chk("R11 wave after first match", {7'b0, wave_out}, 8'h01);
    repeat (4) @(negedge bus_clk);
    rd(3'd0, c1);
    repeat (50) @(negedge bus_clk);
    rd(3'd0, v); chk("R6 stopped holds", v, c1);

    // R10 masking
    wr(3'd4, 8'h00);
    chk("R10 masked irqs", {6'b0, irq_match, irq_ovf}, 8'h00);
    rd(3'd5, v); chk("R10 flags remain", v, 8'h03);

    // R9 write-one-clear
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R9 clear overflow only", v, 8'h02);
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R9 zero no effect", v, 8'h02);
    wr(3'd5, 8'h02);
    rd(3'd5, v); chk("R9 clear match", v, 8'h00);
    wr(3'd4, 8'h03);

    // R8 count load blocks next match: overflow must come first
    wr(3'd1, 8'd50);
    wr(3'd0, 8'd60);
    wait_idle("R8");
    wr(3'd2, 8'h01);
    wait_idle("R8");
    exp_q.push_back(EV_OVF);
    exp_q.push_back(EV_MATCH);
    wr(3'd0, 8'd50);
    wait_events("R8");
    wr(3'd2, 8'h00);
    wait_idle("R8");
    chk("R8 wave one toggle", {7'b0, wave_out}, 8'h00);
    wr(3'd5, 8'h03);

    // R2 oscillator clock
    wr(3'd3, 8'h08);
    rd(3'd3, v); chk("R2 select readback", v, 8'h08);
    wr(3'd1, 8'd100);
    rd(3'd3, v); chk("R3 async compare busy", v, 8'h0A);
    wait_idle("R2");
    wr(3'd0, 8'd0);
    wait_idle("R2");
    repeat (4) @(negedge bus_clk);
    rd(3'd0, v); chk("R2 async count load", v, 8'd0);
    exp_q.push_back(EV_MATCH);
    exp_q.push_back(EV_OVF);
    wr(3'd2, 8'h01);
    wait_events("R2");
    wr(3'd2, 8'h00);
    wait_idle("R2");
    rd(3'd5, v); chk("R2 async flags", v, 8'h03);
    chk("R11 wave async match", {7'b0, wave_out}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule